// File: doc/BRIEF.md
# Metering Front-End SPI Register Slave

This block is the peripheral side of a serial control link for a polyphase metering front end. An external master, clocking in SPI mode 1 (clock idles low, data launched on the rising edge and sampled on the falling edge), opens a frame by pulling the chip select low. It then sends a command byte. Bit 7 of that byte chooses the direction (1 = write, 0 = read) and bits 6:0 name a register. Each register has a fixed width of one, two or three bytes, and the frame length follows from the address. Write data arrives most significant byte first. Read data leaves most significant byte first, while the master clocks out zero bytes.

The register file holds the control state the rest of the front end consumes. An operating-mode register carries a self-clearing soft-reset bit and a three-bit power-down field. A waveform-mode register carries a two-bit sample-rate selector. A 24-bit interrupt mask carries the new-waveform-data enable. The decoded results appear as plain output pins. Two measurement registers are read-only over SPI. The on-chip datapath fills them through a valid/ready write port.

Top module: `meter_spi_regs`

## Requirements
- R1: After reset the decoded outputs are `pwr_down`=0, `rate_sel`=0, `rate_sps`=26040 and `wave_irq_en`=0. Over SPI the operating-mode register (address 0x10, 1 byte) reads 0x04, the waveform-mode register (0x11, 1 byte) reads 0x00, the gain register (0x20, 2 bytes) reads 0x0100, the interrupt mask (0x21, 3 bytes) reads 0x000000, and the measurement registers (0x30, 3 bytes; 0x31, 2 bytes) read zero.
- R2: A write frame of command byte {1, addr[6:0]} followed by one data byte updates a 1-byte register. The new value is visible on the decoded outputs and on a later read.
- R3: Write frames to 2-byte and 3-byte registers take the data most significant byte first, each byte MSB first.
- R4: A read frame of command byte {0, addr[6:0]} returns the register contents MSB first. The first data bit is driven after the first rising SCLK edge that follows the command byte, and every bit is valid at the falling edge. MISO is low while CS_n is high, during the command byte, and after the last data bit.
- R5: The frame length is fixed by the address. Data bits the master clocks beyond the register's width are ignored on writes and read back as zeros.
- R6: Raising CS_n before the last data bit of a write frame leaves every register unchanged.
- R7: An address outside the map reads as zero (one byte), and writes to it change no register.
- R8: The measurement registers ignore SPI writes. The host port writes them on a clock edge where both `hw_valid` and `hw_ready` are high. `hw_ready` falls only in the cycle an SPI write frame commits, and the host holds `hw_valid`, `hw_addr` and `hw_data` until it is accepted. Host writes to any other address are ignored.
- R9: Writing 1 to bit 6 of the operating-mode register returns every register, including the measurement registers, to its reset value. Bit 6 then reads back as 0.
- R10: `pwr_down` is high exactly when bits 5:3 of the operating-mode register are all ones.
- R11: `rate_sel` equals bits 6:5 of the waveform-mode register, and `rate_sps` equals 26040 shifted right by `rate_sel`, giving 26040, 13020, 6510 or 3255.
- R12: `wave_irq_en` equals bit 16 of the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the master, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| hw_valid | input | 1 | Host write request for a measurement register |
| hw_ready | output | 1 | Host write accepted on this edge when high with hw_valid |
| hw_addr | input | 7 | Host write register address |
| hw_data | input | 24 | Host write value, low bits used for narrower registers |
| pwr_down | output | 1 | Power-down request decoded from the operating mode |
| rate_sel | output | 2 | Waveform sample-rate selector |
| rate_sps | output | 15 | Selected waveform rate in samples per second |
| wave_irq_en | output | 1 | New-waveform-data interrupt enable |

## Verification
The bench aims at frame-length handling. If the byte count for the address were wrong, an extra trailing byte would land in a 16-bit register, and a 24-bit write cut short by CS_n would half-commit. It checks that the first response bit is already on MISO at the first data rising edge; a design that loaded the shift register one edge late would return every read shifted by one bit. It drives soft reset after dirtying several registers, which exposes a reset bit that sticks or a reset that spares the measurement registers. It also checks that out-of-map and read-only addresses swallow writes without touching their neighbours.

// File: rtl/meter_spi_pkg.sv
package meter_spi_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 3;
  localparam int DATA_W    = BYTE_W * MAX_BYTES;
  localparam int ADDR_W    = 7;
  localparam int CNT_W     = $clog2(BYTE_W * (MAX_BYTES + 1) + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // register map
  localparam addr_t A_MODE   = 7'h10;
  localparam addr_t A_WAVE   = 7'h11;
  localparam addr_t A_GAIN   = 7'h20;
  localparam addr_t A_MASK   = 7'h21;
  localparam addr_t A_MEAS   = 7'h30;
  localparam addr_t A_ENERGY = 7'h31;

  localparam logic [7:0]  MODE_DEF = 8'h04;
  localparam logic [7:0]  WAVE_DEF = 8'h00;
  localparam logic [15:0] GAIN_DEF = 16'h0100;
  localparam logic [23:0] MASK_DEF = 24'h000000;

  // field positions the decoders depend on
  localparam int SRST_BIT  = 6;
  localparam int PD_LO     = 3;
  localparam int PD_HI     = 5;
  localparam int RATE_LO   = 5;
  localparam int RATE_HI   = 6;
  localparam int WIRQ_BIT  = 16;

  function automatic logic [1:0] reg_bytes(addr_t a);
    case (a)
      A_GAIN, A_ENERGY: return 2'd2;
      A_MASK, A_MEAS:   return 2'd3;
      default:          return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel,
  output logic mosi_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE = 3'b010; // {sclk, cs_n, mosi}

  logic [NPIN-1:0] raw;
  logic [NPIN-1:0] synced;
  logic            sclk_prev;

  assign raw = {sclk, cs_n, mosi};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE[p]}};
      else        chain <= {chain[STAGES-2:0], raw[p]};
    end
    assign synced[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[2];
  end

  assign sclk_rise = synced[2] & ~sclk_prev;
  assign sclk_fall = ~synced[2] & sclk_prev;
  assign sel       = ~synced[1];
  assign mosi_s    = synced[0];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import meter_spi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  mosi_s,
  output addr_t rd_addr,
  input  word_t rd_data,
  output logic  wr_stb,
  output addr_t wr_addr,
  output word_t wr_data,
  output logic  miso
);
  logic [CNT_W-1:0] bitcnt;
  logic [6:0]       cmd_q;
  logic             is_wr;
  logic [1:0]       nbytes;
  logic             done;
  word_t            sh_in;
  word_t            sh_out;
  logic [1:0]       nb_new;
  logic [CNT_W-1:0] last_cnt;
  word_t            rd_aligned;

  // address completes on the eighth falling edge
  assign rd_addr    = {cmd_q[5:0], mosi_s};
  assign nb_new     = reg_bytes(rd_addr);
  assign rd_aligned = rd_data << (BYTE_W * (MAX_BYTES - int'(nb_new)));
  assign last_cnt   = CNT_W'(BYTE_W * int'(nbytes) + BYTE_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt  <= '0;
      cmd_q   <= '0;
      is_wr   <= 1'b0;
      nbytes  <= 2'd1;
      done    <= 1'b0;
      sh_in   <= '0;
      sh_out  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      miso    <= 1'b0;
    end else if (!sel) begin
      bitcnt <= '0;
      done   <= 1'b0;
      wr_stb <= 1'b0;
      miso   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (sclk_fall && !done) begin
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt < CNT_W'(BYTE_W - 1)) begin
          cmd_q <= {cmd_q[5:0], mosi_s};
        end else if (bitcnt == CNT_W'(BYTE_W - 1)) begin
          is_wr   <= cmd_q[6];
          wr_addr <= rd_addr;
          nbytes  <= nb_new;
          sh_out  <= rd_aligned;
          sh_in   <= '0;
        end else begin
          sh_in <= {sh_in[DATA_W-2:0], mosi_s};
          if (bitcnt == last_cnt) begin
            done    <= 1'b1;
            wr_stb  <= is_wr;
            wr_data <= {sh_in[DATA_W-2:0], mosi_s};
          end
        end
      end
      if (sclk_rise) begin
        if (bitcnt >= CNT_W'(BYTE_W) && !done && !is_wr) begin
          miso   <= sh_out[DATA_W-1];
          sh_out <= {sh_out[DATA_W-2:0], 1'b0};
        end else begin
          miso <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/meter_regfile.sv
module meter_regfile
  import meter_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  addr_t      rd_addr,
  output word_t      rd_data,
  input  logic       spi_wr_stb,
  input  addr_t      spi_wr_addr,
  input  word_t      spi_wr_data,
  input  logic       hw_valid,
  output logic       hw_ready,
  input  addr_t      hw_addr,
  input  word_t      hw_data,
  output logic       srst,
  output logic [7:0] mode_q,
  output logic [7:0] wave_q,
  output logic [23:0] mask_q
);
  logic [15:0] gain_q;
  logic [23:0] meas_q;
  logic [15:0] energy_q;

  assign hw_ready = ~spi_wr_stb;
  assign srst     = spi_wr_stb && (spi_wr_addr == A_MODE) && spi_wr_data[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_DEF;
      wave_q   <= WAVE_DEF;
      gain_q   <= GAIN_DEF;
      mask_q   <= MASK_DEF;
      meas_q   <= '0;
      energy_q <= '0;
    end else if (srst) begin
      mode_q   <= MODE_DEF;
      wave_q   <= WAVE_DEF;
      gain_q   <= GAIN_DEF;
      mask_q   <= MASK_DEF;
      meas_q   <= '0;
      energy_q <= '0;
    end else if (spi_wr_stb) begin
      case (spi_wr_addr)
        A_MODE:  mode_q <= spi_wr_data[7:0];
        A_WAVE:  wave_q <= spi_wr_data[7:0];
        A_GAIN:  gain_q <= spi_wr_data[15:0];
        A_MASK:  mask_q <= spi_wr_data[23:0];
        default: ;
      endcase
    end else if (hw_valid) begin
      case (hw_addr)
        A_MEAS:   meas_q   <= hw_data[23:0];
        A_ENERGY: energy_q <= hw_data[15:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:   rd_data = DATA_W'(mode_q);
      A_WAVE:   rd_data = DATA_W'(wave_q);
      A_GAIN:   rd_data = DATA_W'(gain_q);
      A_MASK:   rd_data = DATA_W'(mask_q);
      A_MEAS:   rd_data = DATA_W'(meas_q);
      A_ENERGY: rd_data = DATA_W'(energy_q);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/meter_spi_regs.sv
module meter_spi_regs
  import meter_spi_pkg::*;
#(
  parameter int BASE_RATE   = 26040,
  parameter int SYNC_STAGES = 2,
  localparam int RATE_W     = $clog2(BASE_RATE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  output logic              pwr_down,
  output logic [1:0]        rate_sel,
  output logic [RATE_W-1:0] rate_sps,
  output logic              wave_irq_en
);
  logic        sclk_rise, sclk_fall, sel, mosi_s;
  addr_t       rd_addr, spi_wr_addr;
  word_t       rd_data, spi_wr_data;
  logic        spi_wr_stb, srst;
  logic [7:0]  mode_q, wave_q;
  logic [23:0] mask_q;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel(sel), .mosi_s(mosi_s)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_stb(spi_wr_stb), .wr_addr(spi_wr_addr),
    .wr_data(spi_wr_data), .miso(miso)
  );

  meter_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .spi_wr_stb(spi_wr_stb), .spi_wr_addr(spi_wr_addr),
    .spi_wr_data(spi_wr_data), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_addr(hw_addr), .hw_data(hw_data), .srst(srst),
    .mode_q(mode_q), .wave_q(wave_q), .mask_q(mask_q)
  );

  assign pwr_down    = &mode_q[PD_HI:PD_LO];
  assign rate_sel    = wave_q[RATE_HI:RATE_LO];
  assign rate_sps    = RATE_W'(BASE_RATE >> rate_sel);
  assign wave_irq_en = mask_q[WIRQ_BIT];
endmodule

// File: rtl/meter_spi_regs_chk.sv
module meter_spi_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_stb,
  input logic       srst,
  input logic       miso,
  input logic       pwr_down,
  input logic [1:0] rate_sel,
  input logic       wave_irq_en
);
  // R4: MISO stays low once the frame select is gone
  a_r4_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);

  // R6: a commit only happens while the frame is still selected
  a_r6_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sel);

  // R2: decoded controls move only after an SPI write commit
  a_r2_only_frames_update: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pwr_down) && $stable(rate_sel) && $stable(wave_irq_en));

  // R9: soft reset returns the decoded controls to their defaults
  a_r9_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !pwr_down && rate_sel == 2'd0 && !wave_irq_en);
endmodule

bind meter_spi_regs meter_spi_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(spi_wr_stb), .srst(srst),
  .miso(miso), .pwr_down(pwr_down), .rate_sel(rate_sel),
  .wave_irq_en(wave_irq_en)
);

// File: tb/tb_meter_spi_regs.sv
`timescale 1ns/1ps
module tb_meter_spi_regs;
  localparam int H = 10; // SPI half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [6:0]  hw_addr = '0;
  logic [23:0] hw_data = '0;
  logic        pwr_down;
  logic [1:0]  rate_sel;
  logic [14:0] rate_sps;
  logic        wave_irq_en;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  meter_spi_regs dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_addr(hw_addr), .hw_data(hw_data), .pwr_down(pwr_down),
    .rate_sel(rate_sel), .rate_sps(rate_sps), .wave_irq_en(wave_irq_en)
  );

  localparam logic [6:0] A_MODE = 7'h10, A_WAVE = 7'h11, A_GAIN = 7'h20,
                         A_MASK = 7'h21, A_MEAS = 7'h30, A_ENERGY = 7'h31,
                         A_HOLE = 7'h05;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic b);
    sclk = 1'b1; mosi = v;
    half();
    b = miso;
    sclk = 1'b0;
    half();
  endtask

  // nbits data bits, wd right-aligned, rd collects the bits seen on MISO
  task automatic spi_frame(input logic [7:0] cmd, input int nbits,
                           input logic [23:0] wd, output logic [23:0] rd);
    logic b;
    rd = '0;
    @(negedge clk); cs_n = 1'b0;
    half();
    for (int i = 7; i >= 0; i--) bit_cycle(cmd[i], b);
    repeat (20) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      bit_cycle(wd[i], b);
      rd = {rd[22:0], b};
    end
    half(); cs_n = 1'b1; mosi = 1'b0;
    half(); half();
  endtask

  task automatic spi_wr(input logic [6:0] a, input int nbytes, input logic [23:0] d);
    logic [23:0] r;
    spi_frame({1'b1, a}, 8 * nbytes, d, r);
  endtask

  task automatic spi_rd(input logic [6:0] a, input int nbytes, output logic [23:0] d);
    spi_frame({1'b0, a}, 8 * nbytes, 24'h0, d);
  endtask

  task automatic host_wr(input logic [6:0] a, input logic [23:0] d);
    logic acc;
    @(negedge clk);
    hw_valid = 1'b1; hw_addr = a; hw_data = d;
    forever begin
      acc = hw_ready;
      @(negedge clk);
      if (acc) break;
    end
    hw_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [23:0] r;
    chk("R1 pwr_down", 32'(pwr_down), 0);
    chk("R1 rate_sel", 32'(rate_sel), 0);
    chk("R1 rate_sps", 32'(rate_sps), 26040);
    chk("R1 wave_irq_en", 32'(wave_irq_en), 0);
    chk("R8 hw_ready idle", 32'(hw_ready), 1);
    spi_rd(A_MODE, 1, r);  chk("R1 mode default", 32'(r), 32'h04);
    spi_rd(A_GAIN, 2, r);  chk("R1 gain default", 32'(r), 32'h0100);
    spi_rd(A_MASK, 3, r);  chk("R1 mask default", 32'(r), 32'h0);
    spi_rd(A_MEAS, 3, r);  chk("R1 meas default", 32'(r), 32'h0);
  endtask

  task automatic t_byte_write_rate();
    logic [23:0] r;
    for (int s = 0; s < 4; s++) begin
      spi_wr(A_WAVE, 1, 24'(8'h1F | (s << 5)));
      chk("R11 rate_sel", 32'(rate_sel), 32'(s));
      chk("R11 rate_sps", 32'(rate_sps), 32'(26040 >> s));
    end
    spi_rd(A_WAVE, 1, r);
    chk("R2 wave readback", 32'(r), 32'h7F);
  endtask

  task automatic t_wide_writes();
    logic [23:0] r;
    spi_wr(A_GAIN, 2, 24'h00A55A);
    spi_rd(A_GAIN, 2, r);  chk("R3 gain 16-bit MSB first", 32'(r), 32'hA55A);
    spi_wr(A_MASK, 3, 24'h812345);
    chk("R12 irq enable bit16 set", 32'(wave_irq_en), 1);
    spi_rd(A_MASK, 3, r);  chk("R3 mask 24-bit MSB first", 32'(r), 32'h812345);
    spi_wr(A_MASK, 3, 24'hFEFFFF);
    chk("R12 irq enable bit16 clear", 32'(wave_irq_en), 0);
  endtask

  task automatic t_power_down();
    logic [23:0] r;
    spi_wr(A_MODE, 1, 24'h3C);
    chk("R10 pwr_down on 111", 32'(pwr_down), 1);
    spi_rd(A_MODE, 1, r);  chk("R2 mode readback", 32'(r), 32'h3C);
    spi_wr(A_MODE, 1, 24'h34);
    chk("R10 pwr_down off 110", 32'(pwr_down), 0);
    spi_wr(A_MODE, 1, 24'h2C);
    chk("R10 pwr_down off 101", 32'(pwr_down), 0);
  endtask

  task automatic t_length();
    logic [23:0] r;
    spi_wr(A_GAIN, 3, 24'h1234FF);
    spi_rd(A_GAIN, 2, r);  chk("R5 extra write byte ignored", 32'(r), 32'h1234);
    spi_rd(A_WAVE, 2, r);  chk("R5 extra read byte zero", 32'(r), 32'h7F00);
  endtask

  task automatic t_abort();
    logic [23:0] r;
    spi_frame({1'b1, A_MASK}, 16, 24'h00ABCD, r);
    spi_rd(A_MASK, 3, r);  chk("R6 short mask frame no update", 32'(r), 32'hFEFFFF);
    spi_frame({1'b1, A_WAVE}, 4, 24'h0, r);
    chk("R6 short wave frame rate kept", 32'(rate_sel), 3);
  endtask

  task automatic t_hole();
    logic [23:0] r;
    spi_wr(A_HOLE, 1, 24'h5A);
    spi_rd(A_HOLE, 1, r);  chk("R7 undefined reads zero", 32'(r), 0);
    spi_rd(A_GAIN, 2, r);  chk("R7 neighbour untouched", 32'(r), 32'h1234);
  endtask

  task automatic t_host_port();
    logic [23:0] r;
    spi_wr(A_MEAS, 3, 24'h777777);
    spi_rd(A_MEAS, 3, r);  chk("R8 SPI write to meas ignored", 32'(r), 0);
    host_wr(A_MEAS, 24'hABCDEF);
    spi_rd(A_MEAS, 3, r);  chk("R8 host write meas", 32'(r), 32'hABCDEF);
    host_wr(A_ENERGY, 24'hFF9876);
    spi_rd(A_ENERGY, 2, r); chk("R8 host write energy", 32'(r), 32'h9876);
    host_wr(A_GAIN, 24'h000001);
    spi_rd(A_GAIN, 2, r);  chk("R8 host write to gain ignored", 32'(r), 32'h1234);
  endtask

  task automatic t_soft_reset();
    logic [23:0] r;
    spi_wr(A_MODE, 1, 24'h38);
    spi_wr(A_MASK, 3, 24'h010000);
    spi_wr(A_MODE, 1, 24'h78);
    chk("R9 pwr_down cleared", 32'(pwr_down), 0);
    chk("R9 rate_sel cleared", 32'(rate_sel), 0);
    chk("R9 irq enable cleared", 32'(wave_irq_en), 0);
    spi_rd(A_MODE, 1, r);  chk("R9 mode default, bit6 self-clears", 32'(r), 32'h04);
    spi_rd(A_GAIN, 2, r);  chk("R9 gain default", 32'(r), 32'h0100);
    spi_rd(A_MEAS, 3, r);  chk("R9 meas cleared", 32'(r), 0);
    spi_rd(A_ENERGY, 2, r); chk("R9 energy cleared", 32'(r), 0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write_rate();
    t_wide_writes();
    t_power_down();
    t_length();
    t_abort();
    t_hole();
    t_host_port();
    t_soft_reset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule